// File: doc/BRIEF.md
# LCD Frame-Word Pixel Unpacker

This block sits between a frame-buffer fetch engine and a colour pipeline. It accepts 32-bit words read from pixel memory, splits each word into as many pixels as the selected depth packs into it, and emits them one at a time over a valid/ready handshake. Pixels of 8 bits or fewer leave as palette indices for a lookup stage elsewhere. Wider pixels leave as 24-bit RGB, with narrow channels widened by zero fill.

The format controls are static inputs: a depth code, a byte-reversal select, a pixel-order select, a red/blue swap select, and a two-bit board mux that chooses the 16-bit packing. The controls must be held steady while pixels of a word are in flight. The parameter `EXTENDED` picks the extended controller variant. In that variant the 16-bit packing follows the depth code alone and the board mux is ignored. The block also drives a combinational byte count per scan line, derived from the active width and the depth code.

Top module: `lcd_pixel_unpacker`

## Requirements
- R1: Depth codes map to bits per pixel as 0→1, 1→2, 2→4, 3→8, 4→16, 5→32, 6→16 (565) and 7→12. A 12-bit pixel occupies a 16-bit slot, so a word holds 32, 16, 8, 4, 2, 1 pixels respectively. With both order selects clear, pixel k of a word is taken from bits [k·b +: b], least significant first.
- R2: With the pixel-order select set and the byte-reversal select clear, the pixels of a word are emitted most significant slot first.
- R3: With the byte-reversal select set, the four bytes of the word are reversed (byte 3 becomes byte 0) before slots are taken least significant first. This select overrides the pixel-order select.
- R4: For depths of 8 bits or fewer, `pix_is_index` is 1, `pix_index` carries the pixel value zero-extended, and `pix_rgb` is 0. For wider depths, `pix_is_index` is 0 and `pix_index` is 0.
- R5: In the base variant with depth code 4, mux value 1 selects 5551: fields [4:0], [9:5], [14:10], with bit 15 ignored. Mux value 3 selects 565 (fields [4:0], [10:5], [15:11]) with red in [4:0] whatever the swap select. Mux values 0 and 2 select 565 and follow the swap select.
- R6: In the extended variant, depth code 4 is always 5551 and the mux is ignored. In both variants, code 6 is 565 and code 7 is 444 (fields [3:0], [7:4], [11:8]), and both follow the swap select.
- R7: For every RGB format, the swap select set puts red in the least significant field and blue in the most significant field. With the select clear, red takes the most significant field. Green is always the middle field. At 32 bpp the fields are bits [7:0], [15:8] and [23:16], and bits [31:24] are ignored. `pix_rgb` is {red, green, blue}, with red in bits [23:16].
- R8: A channel narrower than 8 bits is widened by a left shift with zero fill into the low bits.
- R9: `bytes_per_line` equals the width shifted right by 3, 2 or 1 for codes 0, 1 and 2. It equals the width for code 3, the width shifted left by 1 for codes 4, 6 and 7, and the width shifted left by 2 for code 5.
- R10: After reset, `pix_valid` is 0 and `word_ready` is 1. A stalled pixel holds steady. A new word is accepted only when no word is held or when the last pixel of the held word is leaving. One pixel is emitted per cycle when `pix_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| depth_sel | input | 3 | Depth code |
| bgr_sel | input | 1 | Red in least significant field when set |
| be_byte_sel | input | 1 | Reverse bytes of each word |
| be_pix_sel | input | 1 | Most significant slot first |
| mux16 | input | 2 | Board mux for 16-bit packing |
| line_width | input | WIDTH_W | Active pixels per line |
| bytes_per_line | output | WIDTH_W+2 | Bytes of frame memory per line |
| word_valid | input | 1 | Fetched word available |
| word_ready | output | 1 | Word accepted this cycle |
| word_data | input | 32 | Fetched word |
| pix_valid | output | 1 | Pixel available |
| pix_ready | input | 1 | Pixel taken this cycle |
| pix_is_index | output | 1 | Pixel is a palette index |
| pix_index | output | 8 | Palette index |
| pix_rgb | output | 24 | Widened colour |

## Verification
The bench builds two copies side by side, one with `EXTENDED` = 0 and one with `EXTENDED` = 1, both at the default `WIDTH_W` of 12. Both copies receive the same words and format settings. This lets a single stimulus show how the board mux and depth code 4 decode differently in the two variants. The 12-bit width allows line widths up to 4095, so the left-shifted byte counts reach the top two bits of `bytes_per_line`. The bench repeats streams with `pix_ready` stalling, so the hold and the word acceptance on the last pixel are exercised against back-to-back flow.

// File: rtl/lcd_pixel_unpacker.sv
module lcd_pixel_unpacker #(
  parameter bit EXTENDED = 1'b0,
  parameter int WIDTH_W  = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [2:0]         depth_sel,
  input  logic               bgr_sel,
  input  logic               be_byte_sel,
  input  logic               be_pix_sel,
  input  logic [1:0]         mux16,
  input  logic [WIDTH_W-1:0] line_width,
  output logic [WIDTH_W+1:0] bytes_per_line,
  input  logic               word_valid,
  output logic               word_ready,
  input  logic [31:0]        word_data,
  output logic               pix_valid,
  input  logic               pix_ready,
  output logic               pix_is_index,
  output logic [7:0]         pix_index,
  output logic [23:0]        pix_rgb
);
  localparam int BPL_W = WIDTH_W + 2;

  logic [31:0] word_q;
  logic        have_q;
  logic [4:0]  idx_q;

  logic [2:0]  lg;
  logic [4:0]  last_idx, slot, shamt;
  logic [31:0] word_sw;
  logic [23:0] raw;
  logic        last, xfer, take;
  logic [7:0]  lo, gr, hi, idx_mask;
  logic        red_low;

  always_comb begin
    case (depth_sel)
      3'd0, 3'd1, 3'd2, 3'd3: lg = depth_sel;
      3'd5:                   lg = 3'd5;
      default:                lg = 3'd4;
    endcase
  end

  assign last_idx = 5'd31 >> lg;
  assign last     = idx_q == last_idx;
  assign xfer     = pix_valid && pix_ready;
  assign word_ready = !have_q || (pix_ready && last);
  assign take     = word_valid && word_ready;
  assign pix_valid = have_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      idx_q  <= '0;
      word_q <= '0;
    end else if (take) begin
      have_q <= 1'b1;
      idx_q  <= '0;
      word_q <= word_data;
    end else if (xfer) begin
      if (last) have_q <= 1'b0;
      else      idx_q  <= idx_q + 5'd1;
    end
  end

  assign word_sw = be_byte_sel ? {word_q[7:0], word_q[15:8], word_q[23:16], word_q[31:24]} : word_q;
  assign slot    = (be_pix_sel && !be_byte_sel) ? last_idx - idx_q : idx_q;
  assign shamt   = slot << lg;
  assign raw     = 24'(word_sw >> shamt);

  always_comb begin
    case (lg)
      3'd0:    idx_mask = 8'h01;
      3'd1:    idx_mask = 8'h03;
      3'd2:    idx_mask = 8'h0F;
      default: idx_mask = 8'hFF;
    endcase
  end

  always_comb begin
    red_low = bgr_sel;
    if (depth_sel == 3'd5) begin
      lo = raw[7:0];  gr = raw[15:8]; hi = raw[23:16];
    end else if (depth_sel == 3'd7) begin
      lo = {raw[3:0], 4'h0}; gr = {raw[7:4], 4'h0}; hi = {raw[11:8], 4'h0};
    end else if (depth_sel == 3'd4 && (EXTENDED || mux16 == 2'd1)) begin
      lo = {raw[4:0], 3'b0}; gr = {raw[9:5], 3'b0}; hi = {raw[14:10], 3'b0};
    end else begin
      lo = {raw[4:0], 3'b0}; gr = {raw[10:5], 2'b0}; hi = {raw[15:11], 3'b0};
      if (!EXTENDED && depth_sel == 3'd4 && mux16 == 2'd3) red_low = 1'b1;
    end
  end

  assign pix_is_index = lg <= 3'd3;
  assign pix_index    = pix_is_index ? (raw[7:0] & idx_mask) : 8'h00;
  assign pix_rgb      = pix_is_index ? 24'h0 :
                        (red_low ? {lo, gr, hi} : {hi, gr, lo});

  always_comb begin
    case (depth_sel)
      3'd0:    bytes_per_line = BPL_W'(line_width >> 3);
      3'd1:    bytes_per_line = BPL_W'(line_width >> 2);
      3'd2:    bytes_per_line = BPL_W'(line_width >> 1);
      3'd3:    bytes_per_line = BPL_W'(line_width);
      3'd5:    bytes_per_line = {line_width, 2'b00};
      default: bytes_per_line = {1'b0, line_width, 1'b0};
    endcase
  end

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_rgb) && $stable(pix_index) && $stable(pix_is_index)); // R10
  AST_ACCEPT_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && word_ready && pix_valid |-> pix_ready); // R10
  AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_is_index |-> ((pix_index & ~idx_mask) == 8'h00) && pix_rgb == 24'h0); // R4
  AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_is_index && (depth_sel == 3'd4 || depth_sel == 3'd6)
      |-> pix_rgb[18:16] == 3'b0 && pix_rgb[2:0] == 3'b0 && pix_rgb[9:8] == 2'b0); // R8
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> word_ready); // R10
endmodule

// File: tb/test_lcd_pixel_unpacker.sv
module test_lcd_pixel_unpacker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]  depth_sel = 3'd0;
  logic        bgr_sel = 1'b0, be_byte_sel = 1'b0, be_pix_sel = 1'b0;
  logic [1:0]  mux16 = 2'd0;
  logic [11:0] line_width = 12'd0;
  logic        word_valid = 1'b0;
  logic [31:0] word_data = 32'h0;
  logic        pix_ready = 1'b1;

  logic [13:0] bpl_a, bpl_b;
  logic        wr_a, wr_b, pv_a, pv_b, ix_a, ix_b;
  logic [7:0]  id_a, id_b;
  logic [23:0] rgb_a, rgb_b;

  lcd_pixel_unpacker #(.EXTENDED(1'b0), .WIDTH_W(12)) i_lcd_pixel_unpacker (
    .clk(clk), .rst_n(rst_n), .depth_sel(depth_sel), .bgr_sel(bgr_sel),
    .be_byte_sel(be_byte_sel), .be_pix_sel(be_pix_sel), .mux16(mux16),
    .line_width(line_width), .bytes_per_line(bpl_a), .word_valid(word_valid),
    .word_ready(wr_a), .word_data(word_data), .pix_valid(pv_a), .pix_ready(pix_ready),
    .pix_is_index(ix_a), .pix_index(id_a), .pix_rgb(rgb_a));

  lcd_pixel_unpacker #(.EXTENDED(1'b1), .WIDTH_W(12)) i_lcd_pixel_unpacker_ext (
    .clk(clk), .rst_n(rst_n), .depth_sel(depth_sel), .bgr_sel(bgr_sel),
    .be_byte_sel(be_byte_sel), .be_pix_sel(be_pix_sel), .mux16(mux16),
    .line_width(line_width), .bytes_per_line(bpl_b), .word_valid(word_valid),
    .word_ready(wr_b), .word_data(word_data), .pix_valid(pv_b), .pix_ready(pix_ready),
    .pix_is_index(ix_b), .pix_index(id_b), .pix_rgb(rgb_b));

  int checks = 0, errors = 0;
  bit done = 0, stall_mode = 0;
  string tag = "R1";
  logic [32:0] qa[$], qb[$];
  logic [32:0] snap;
  bit stall_prev = 0;
  int rcnt = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  function automatic logic [32:0] model(input logic [31:0] w, input int k, input bit ext);
    int l, bits, n, pos;
    logic [31:0] wb;
    logic [63:0] v;
    logic [7:0] lo, g, hi, r, b;
    bit redlow;
    l = (depth_sel <= 3) ? int'(depth_sel) : (depth_sel == 5 ? 5 : 4);
    bits = 1 << l;
    n = 32 / bits;
    wb = be_byte_sel ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    pos = (be_pix_sel && !be_byte_sel) ? n - 1 - k : k;
    v = ({32'h0, wb} >> (pos * bits)) & ((64'd1 << bits) - 64'd1);
    if (bits <= 8) return {1'b1, v[7:0], 24'h0};
    redlow = bgr_sel;
    if (depth_sel == 5) begin
      lo = v[7:0]; g = v[15:8]; hi = v[23:16];
    end else if (depth_sel == 7) begin
      lo = {v[3:0], 4'h0}; g = {v[7:4], 4'h0}; hi = {v[11:8], 4'h0};
    end else if (depth_sel == 4 && (ext || mux16 == 2'd1)) begin
      lo = {v[4:0], 3'h0}; g = {v[9:5], 3'h0}; hi = {v[14:10], 3'h0};
    end else begin
      lo = {v[4:0], 3'h0}; g = {v[10:5], 2'h0}; hi = {v[15:11], 3'h0};
      if (depth_sel == 4 && !ext && mux16 == 2'd3) redlow = 1;
    end
    r = redlow ? lo : hi;
    b = redlow ? hi : lo;
    return {1'b0, 8'h0, r, g, b};
  endfunction

  always @(posedge clk) begin
    rcnt <= rcnt + 1;
    #1 pix_ready = stall_mode ? (rcnt[0] ^ rcnt[2]) : 1'b1;
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (stall_prev)
        chk({pv_a, ix_a, id_a, rgb_a} == {1'b1, snap}, "R10 hold", {pv_a, ix_a, id_a, rgb_a}, {1'b1, snap});
      stall_prev = pv_a && !pix_ready;
      snap = {ix_a, id_a, rgb_a};
      if (pv_a && pix_ready) begin
        if (qa.size() == 0) chk(0, "R10 extra pixel base", {ix_a, id_a, rgb_a}, 0);
        else begin
          logic [32:0] e;
          e = qa.pop_front();
          chk({ix_a, id_a, rgb_a} == e, {tag, " base"}, {ix_a, id_a, rgb_a}, e);
        end
      end
      if (pv_b && pix_ready) begin
        if (qb.size() == 0) chk(0, "R10 extra pixel ext", {ix_b, id_b, rgb_b}, 0);
        else begin
          logic [32:0] e;
          e = qb.pop_front();
          chk({ix_b, id_b, rgb_b} == e, {tag, " ext"}, {ix_b, id_b, rgb_b}, e);
        end
      end
    end
  end

  task automatic send(input logic [31:0] w);
    int n;
    bit ok;
    n = (depth_sel <= 3) ? (32 >> depth_sel) : (depth_sel == 5 ? 1 : 2);
    for (int k = 0; k < n; k++) begin
      qa.push_back(model(w, k, 1'b0));
      qb.push_back(model(w, k, 1'b1));
    end
    @(negedge clk);
    word_valid = 1'b1;
    word_data = w;
    forever begin
      ok = wr_a && wr_b;
      @(posedge clk);
      if (ok) break;
      @(negedge clk);
    end
    @(negedge clk);
    word_valid = 1'b0;
  endtask

  task automatic drain();
    while (qa.size() != 0 || qb.size() != 0 || pv_a || pv_b) @(negedge clk);
  endtask

  task automatic cfg(input string t, input logic [2:0] d, input bit bgr, input bit bb, input bit bp, input logic [1:0] mx);
    drain();
    tag = t;
    depth_sel = d; bgr_sel = bgr; be_byte_sel = bb; be_pix_sel = bp; mux16 = mx;
  endtask

  task automatic bpl(input logic [2:0] d, input logic [11:0] w, input logic [13:0] exp);
    drain();
    depth_sel = d; line_width = w;
    #1;
    chk(bpl_a == exp && bpl_b == exp, "R9 bytes per line", bpl_a, exp);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R10 watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!pv_a && !pv_b, "R10 reset pix_valid", {pv_a, pv_b}, 0);
    chk(wr_a && wr_b, "R10 reset word_ready", {wr_a, wr_b}, 2'b11);
    rst_n = 1'b1;

    bpl(3'd0, 12'd640, 14'd80);
    bpl(3'd1, 12'd640, 14'd160);
    bpl(3'd2, 12'd100, 14'd50);
    bpl(3'd3, 12'd777, 14'd777);
    bpl(3'd4, 12'd640, 14'd1280);
    bpl(3'd6, 12'd4095, 14'd8190);
    bpl(3'd7, 12'd320, 14'd640);
    bpl(3'd5, 12'd4095, 14'd16380);
    bpl(3'd0, 12'd15, 14'd1);

    for (int s = 0; s < 2; s++) begin
      stall_mode = (s == 1);
      for (int d = 0; d < 4; d++) begin
        cfg("R1 R4 lsb first", 3'(d), 0, 0, 0, 2'd0);
        send(32'hA5C3_0F81); send(32'h1234_5678);
        cfg("R2 msb first", 3'(d), 0, 0, 1, 2'd0);
        send(32'hA5C3_0F81);
        cfg("R3 byte reverse", 3'(d), 0, 1, 0, 2'd0);
        send(32'h8001_F05A);
        cfg("R3 byte reverse overrides order", 3'(d), 0, 1, 1, 2'd0);
        send(32'h8001_F05A);
      end
      for (int m = 0; m < 4; m++) begin
        for (int g = 0; g < 2; g++) begin
          cfg("R5 R6 R8 sixteen bit mux", 3'd4, g[0], 0, 0, 2'(m));
          send(32'hF81F_87E0); send(32'h7C01_8421);
        end
      end
      cfg("R6 code 6", 3'd6, 0, 0, 1, 2'd1); send(32'hF800_07E1);
      cfg("R6 code 6 swap", 3'd6, 1, 0, 0, 2'd3); send(32'hF800_07E1);
      cfg("R6 R8 code 7", 3'd7, 0, 0, 0, 2'd2); send(32'hF321_0ABC);
      cfg("R6 code 7 swap", 3'd7, 1, 1, 0, 2'd0); send(32'hF321_0ABC);
      cfg("R7 32 bpp", 3'd5, 0, 0, 0, 2'd0); send(32'hFF11_2233); send(32'h00AB_CDEF);
      cfg("R7 32 bpp swap", 3'd5, 1, 0, 1, 2'd0); send(32'hFF11_2233);
      cfg("R7 32 bpp byte reverse", 3'd5, 0, 1, 0, 2'd0); send(32'h4433_2211);
      cfg("R10 back to back", 3'd4, 0, 0, 0, 2'd2);
      for (int i = 0; i < 6; i++) send(32'h1357_9BDF + 32'(i));
    end
    drain();
    chk(qa.size() == 0 && qb.size() == 0, "R10 all pixels delivered", qa.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule